// File: doc/BRIEF.md
# Time-of-Day Calendar Update Engine

This block keeps a wall-clock time and calendar: seconds, minutes, hours, day of week, date of month, month and a two-digit year, together with three alarm bytes for seconds, minutes and hours. Each pulse on the one-second strobe advances the time by one second. The carries run through to the calendar, with month lengths and leap years taken into account, and an optional daylight-saving rule moves the clock forward one hour in spring and back one hour in autumn. Values are held and counted in whichever encoding the data-mode input selects, plain binary or BCD. The hours byte follows the hour-format input, either 24-hour or 12-hour with a PM flag.

Two copies of the time are held. The internal copy advances on every strobe. The user copy is the one the host reads, and it follows the internal copy unless the hold input is high, in which case it stays frozen. A host write loads a byte into both copies. After each advance the new time is compared with the alarm bytes, and a match pulse is raised. An alarm byte whose two top bits are both set matches any value. An update-ended pulse follows one clock after every advance.

Top module: `tod_calendar`

## Requirements
- R1: After reset, time bytes read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00. All three alarm bytes read 00, and both pulse outputs are low. Read map: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 seconds alarm, 8 minutes alarm, 9 hours alarm. Other addresses read 00.
- R2: Bit 7 of the seconds byte always reads 0. A write to address 0 stores only bits 6..0.
- R3: With bin_mode=0 (BCD, tens digit in bits 7..4, ones digit in bits 3..0), every strobe adds one second. Seconds and minutes wrap 59 to 0 and carry, and 24-hour hours wrap 23 to 0 and advance the day.
- R4: With bin_mode=1 every byte holds the plain binary value, and the same counting and carries as R3 apply.
- R5: With hr24=0 the hours byte holds 1..12 in bits 6..0, and bit 7 set means PM. 11:59:59 AM goes to 12:00:00 PM, 12:59:59 PM goes to 1:00:00 PM, and 11:59:59 PM goes to 12:00:00 AM of the next day. With hr24=1 the hours byte holds 0..23.
- R6: At a day change the day of week goes 7 to 1 and otherwise adds one. The date wraps to 1 past the month length, which is 30 for months 4, 6, 9 and 11, 28 for month 2 (29 when the year value is divisible by 4), and 31 otherwise. Month 12 wraps to 1 and year 99 wraps to 0.
- R7: alarm_pulse is high for exactly the one cycle after a strobe when the new seconds, minutes and hours each equal their alarm byte, or the alarm byte has bits 7 and 6 both set. Alarm bytes are never changed by updates.
- R8: With dst_en=1, a strobe at 1:59:59 AM on a day with month 4, day of week 1 and date 1..7 gives 3:00:00 AM. With dst_en=0, or on any other date, the result is 2:00:00.
- R9: With dst_en=1, a strobe at 1:59:59 AM on a day with month 10, day of week 1 and date 25..31 gives 1:00:00 AM. This happens only once per day: the next 1:59:59 that same day advances normally, and the rule is armed again by the next day change.
- R10: While hold_user=1 strobes leave the readable time unchanged and the internal copy keeps counting. The first strobe after hold_user returns to 0 shows the internal time.
- R11: uend_pulse is high for exactly one cycle, two cycles after the strobe cycle, which is one cycle after the cycle in which alarm_pulse can be high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_strobe | input | 1 | One-cycle pulse: advance one second |
| bin_mode | input | 1 | 1 binary, 0 BCD |
| hr24 | input | 1 | 1 24-hour, 0 12-hour with PM flag |
| dst_en | input | 1 | Enables the daylight-saving jumps |
| hold_user | input | 1 | Freezes the readable copy |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 4 | Byte address for writes |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | 4 | Byte address for reads |
| rd_data | output | 8 | Byte read from the user copy or the alarm bytes |
| alarm_pulse | output | 1 | One-cycle alarm match pulse |
| uend_pulse | output | 1 | One-cycle update-ended pulse |

## Verification
A wrong carry or month-length decision in the internal copy shows up on the very next read, because the user copy is loaded from that copy on the same clock edge as the advance. The bench therefore reads the bytes straight after each strobe, across every hour of the day in all four encodings and across every month end in a leap year and in a non-leap year. A daylight-saving state that is stuck or never cleared only shows at the next qualifying 1:59:59, so the autumn case is repeated within one day and again after a day change. Pulse-timing faults are visible within two cycles of any strobe.

// File: rtl/tod_cal_pkg.sv
package tod_cal_pkg;
    parameter int BYTE_W    = 8;
    parameter int ADDR_W    = 4;
    parameter int ALM_N     = 3;

    localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_HR   = 4'd2;
    localparam logic [ADDR_W-1:0] A_DOW  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DATE = 4'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 4'd5;
    localparam logic [ADDR_W-1:0] A_YR   = 4'd6;
    localparam logic [ADDR_W-1:0] A_ASEC = 4'd7;
    localparam logic [ADDR_W-1:0] A_AMIN = 4'd8;
    localparam logic [ADDR_W-1:0] A_AHR  = 4'd9;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t yr;
        byte_t mon;
        byte_t date;
        byte_t dow;
        byte_t hr;
        byte_t min;
        byte_t sec;
    } tod_t;

    typedef struct packed {
        byte_t hr;
        byte_t min;
        byte_t sec;
    } alm_t;

    localparam tod_t TOD_RESET = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                   dow: 8'h01, hr: 8'h00, min: 8'h00,
                                   sec: 8'h00};

    // encoded byte -> binary value
    function automatic byte_t dec_byte(byte_t b, logic bin);
        byte_t r;
        if (bin) r = b;
        else     r = {4'b0, b[7:4]} * 8'd10 + {4'b0, b[3:0]};
        return r;
    endfunction

    // binary value -> encoded byte
    function automatic byte_t enc_byte(byte_t v, logic bin);
        byte_t t;
        byte_t o;
        if (bin) return v;
        t = v / 8'd10;
        o = v % 8'd10;
        return {t[3:0], o[3:0]};
    endfunction

    // hours byte -> 0..23
    function automatic byte_t dec_hour(byte_t b, logic bin, logic h24);
        byte_t h;
        if (h24) return dec_byte(b, bin);
        h = dec_byte({1'b0, b[6:0]}, bin);
        if (h == 8'd12) h = 8'd0;
        if (b[7]) h = h + 8'd12;
        return h;
    endfunction

    // 0..23 -> hours byte
    function automatic byte_t enc_hour(byte_t h, logic bin, logic h24);
        byte_t h12;
        byte_t e;
        if (h24) return enc_byte(h, bin);
        h12 = h % 8'd12;
        if (h12 == 8'd0) h12 = 8'd12;
        e = enc_byte(h12, bin);
        return {(h >= 8'd12), e[6:0]};
    endfunction

    function automatic byte_t month_len(byte_t mon, byte_t yr);
        case (mon)
            8'd2:                     return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
            default:                  return 8'd31;
        endcase
    endfunction

    function automatic tod_t put_tod(tod_t t, logic [ADDR_W-1:0] a, byte_t d);
        tod_t r;
        r = t;
        case (a)
            A_SEC:   r.sec  = {1'b0, d[6:0]};
            A_MIN:   r.min  = d;
            A_HR:    r.hr   = d;
            A_DOW:   r.dow  = d;
            A_DATE:  r.date = d;
            A_MON:   r.mon  = d;
            A_YR:    r.yr   = d;
            default: r = t;
        endcase
        return r;
    endfunction

    function automatic alm_t put_alm(alm_t t, logic [ADDR_W-1:0] a, byte_t d);
        alm_t r;
        r = t;
        case (a)
            A_ASEC:  r.sec = d;
            A_AMIN:  r.min = d;
            A_AHR:   r.hr  = d;
            default: r = t;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tod_cal_step.sv
module tod_cal_step
    import tod_cal_pkg::*;
(
    input  tod_t cur,
    input  logic bin_mode,
    input  logic hr24,
    input  logic dst_en,
    input  logic fall_done,
    output tod_t nxt,
    output logic fall_hit,
    output logic day_roll
);
    byte_t s, m, h, w, d, mo, y;
    logic  at_159;
    logic  spring, fall;

    always_comb begin
        s  = dec_byte(cur.sec, bin_mode);
        m  = dec_byte(cur.min, bin_mode);
        h  = dec_hour(cur.hr, bin_mode, hr24);
        w  = dec_byte(cur.dow, bin_mode);
        d  = dec_byte(cur.date, bin_mode);
        mo = dec_byte(cur.mon, bin_mode);
        y  = dec_byte(cur.yr, bin_mode);

        at_159 = (h == 8'd1) && (m == 8'd59) && (s == 8'd59);
        spring = dst_en && at_159 && (mo == 8'd4) && (w == 8'd1) && (d <= 8'd7);
        fall   = dst_en && at_159 && !fall_done && (mo == 8'd10) &&
                 (w == 8'd1) && (d >= 8'd25);

        fall_hit = 1'b0;
        day_roll = 1'b0;

        if (spring) begin
            h = 8'd3;
            m = 8'd0;
            s = 8'd0;
        end else if (fall) begin
            m = 8'd0;
            s = 8'd0;
            fall_hit = 1'b1;
        end else if (s >= 8'd59) begin
            s = 8'd0;
            if (m >= 8'd59) begin
                m = 8'd0;
                if (h >= 8'd23) begin
                    h = 8'd0;
                    day_roll = 1'b1;
                    w = (w >= 8'd7) ? 8'd1 : w + 8'd1;
                    if (d >= month_len(mo, y)) begin
                        d = 8'd1;
                        if (mo >= 8'd12) begin
                            mo = 8'd1;
                            y  = (y >= 8'd99) ? 8'd0 : y + 8'd1;
                        end else begin
                            mo = mo + 8'd1;
                        end
                    end else begin
                        d = d + 8'd1;
                    end
                end else begin
                    h = h + 8'd1;
                end
            end else begin
                m = m + 8'd1;
            end
        end else begin
            s = s + 8'd1;
        end

        nxt.sec  = enc_byte(s, bin_mode);
        nxt.min  = enc_byte(m, bin_mode);
        nxt.hr   = enc_hour(h, bin_mode, hr24);
        nxt.dow  = enc_byte(w, bin_mode);
        nxt.date = enc_byte(d, bin_mode);
        nxt.mon  = enc_byte(mo, bin_mode);
        nxt.yr   = enc_byte(y, bin_mode);
    end
endmodule

// File: rtl/tod_cal_alarm.sv
module tod_cal_alarm
    import tod_cal_pkg::*;
(
    input  tod_t tim,
    input  alm_t alm,
    output logic hit
);
    logic [ALM_N-1:0][BYTE_W-1:0] t_b;
    logic [ALM_N-1:0][BYTE_W-1:0] a_b;
    logic [ALM_N-1:0]             field_ok;

    assign t_b = {tim.hr, tim.min, tim.sec};
    assign a_b = alm;

    for (genvar i = 0; i < ALM_N; i++) begin : g_field
        assign field_ok[i] = (a_b[i][BYTE_W-1 -: 2] == 2'b11) || (a_b[i] == t_b[i]);
    end

    assign hit = &field_ok;
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
    import tod_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_strobe,
    input  logic              bin_mode,
    input  logic              hr24,
    input  logic              dst_en,
    input  logic              hold_user,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              alarm_pulse,
    output logic              uend_pulse
);
    tod_t int_q, usr_q, int_n, usr_n, nxt;
    alm_t alm_q, alm_n;
    logic fall_done_q, fall_hit, day_roll, hit, upd_d;

    tod_cal_step u_step (
        .cur       (int_q),
        .bin_mode  (bin_mode),
        .hr24      (hr24),
        .dst_en    (dst_en),
        .fall_done (fall_done_q),
        .nxt       (nxt),
        .fall_hit  (fall_hit),
        .day_roll  (day_roll)
    );

    tod_cal_alarm u_alarm (
        .tim (nxt),
        .alm (alm_q),
        .hit (hit)
    );

    always_comb begin
        int_n = upd_strobe ? nxt : int_q;
        usr_n = (upd_strobe && !hold_user) ? nxt : usr_q;
        alm_n = alm_q;
        if (wr_en) begin
            int_n = put_tod(int_n, wr_addr, wr_data);
            usr_n = put_tod(usr_n, wr_addr, wr_data);
            alm_n = put_alm(alm_q, wr_addr, wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q       <= TOD_RESET;
            usr_q       <= TOD_RESET;
            alm_q       <= '0;
            fall_done_q <= 1'b0;
            upd_d       <= 1'b0;
            alarm_pulse <= 1'b0;
            uend_pulse  <= 1'b0;
        end else begin
            int_q       <= int_n;
            usr_q       <= usr_n;
            alm_q       <= alm_n;
            upd_d       <= upd_strobe;
            alarm_pulse <= upd_strobe && hit;
            uend_pulse  <= upd_d;
            if (upd_strobe) begin
                if (fall_hit)      fall_done_q <= 1'b1;
                else if (day_roll) fall_done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = usr_q.sec;
            A_MIN:   rd_data = usr_q.min;
            A_HR:    rd_data = usr_q.hr;
            A_DOW:   rd_data = usr_q.dow;
            A_DATE:  rd_data = usr_q.date;
            A_MON:   rd_data = usr_q.mon;
            A_YR:    rd_data = usr_q.yr;
            A_ASEC:  rd_data = alm_q.sec;
            A_AMIN:  rd_data = alm_q.min;
            A_AHR:   rd_data = alm_q.hr;
            default: rd_data = '0;
        endcase
    end

    // R2: top bit of seconds stays clear in both copies
    p_sec_msb_r2: assert property (@(posedge clk) disable iff (rst)
        !usr_q.sec[7] && !int_q.sec[7]);

    // R10: user copy frozen while held and not written
    p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(hold_user) && !$past(wr_en)) |-> $stable(usr_q));

    // R7: alarm pulse only right after a strobe
    p_alarm_after_upd_r7: assert property (@(posedge clk) disable iff (rst)
        alarm_pulse |-> $past(upd_strobe));

    // R11: update-ended pulse two cycles after the strobe
    p_uend_lag_r11: assert property (@(posedge clk) disable iff (rst)
        uend_pulse |-> $past(upd_strobe, 2));

    // R11: update-ended pulse never lasts two cycles for an isolated strobe
    p_uend_single_r11: assert property (@(posedge clk) disable iff (rst)
        (uend_pulse && !$past(upd_strobe)) |=> !uend_pulse);
endmodule

// File: tb/tod_calendar_bench.sv
module tod_calendar_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_strobe = 1'b0;
    logic       bin_mode = 1'b0;
    logic       hr24 = 1'b1;
    logic       dst_en = 1'b0;
    logic       hold_user = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       alarm_pulse, uend_pulse;

    int checks = 0;
    int failures = 0;
    logic a_seen, u_first, u_seen;

    always #5 clk = ~clk;

    tod_calendar u_tod_calendar (
        .clk(clk), .rst(rst), .upd_strobe(upd_strobe), .bin_mode(bin_mode),
        .hr24(hr24), .dst_en(dst_en), .hold_user(hold_user), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .alarm_pulse(alarm_pulse), .uend_pulse(uend_pulse)
    );

    function automatic int benc(int v);
        return bin_mode ? v : (((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int bhr(int h);
        int h12;
        if (hr24) return benc(h);
        h12 = h % 12;
        if (h12 == 0) h12 = 12;
        return benc(h12) | ((h >= 12) ? 8'h80 : 0);
    endfunction

    function automatic int mlen(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        rd_addr = a[3:0];
        #1;
        v = rd_data;
    endtask

    task automatic upd();
        @(negedge clk);
        upd_strobe = 1'b1;
        @(negedge clk);
        upd_strobe = 1'b0;
        a_seen  = alarm_pulse;
        u_first = uend_pulse;
        @(negedge clk);
        u_seen = uend_pulse;
    endtask

    task automatic set_time(int h, int m, int s, int w, int d, int mo, int y);
        wr(0, benc(s)); wr(1, benc(m)); wr(2, bhr(h));
        wr(3, benc(w)); wr(4, benc(d)); wr(5, benc(mo)); wr(6, benc(y));
    endtask

    task automatic chk_time(string tag, int h, int m, int s, int w, int d, int mo, int y);
        int v;
        rd(0, v); chk(tag, v, benc(s));
        rd(1, v); chk(tag, v, benc(m));
        rd(2, v); chk(tag, v, bhr(h));
        rd(3, v); chk(tag, v, benc(w));
        rd(4, v); chk(tag, v, benc(d));
        rd(5, v); chk(tag, v, benc(mo));
        rd(6, v); chk(tag, v, benc(y));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_time("R1", 0, 0, 0, 1, 1, 1, 0);
        for (int a = 7; a < 12; a++) begin rd(a, v); chk("R1", v, 0); end
        chk("R1 alarm", alarm_pulse, 0);
        chk("R1 uend", uend_pulse, 0);

        // R2 seconds top bit read-only
        bin_mode = 1'b1;
        wr(0, 8'hA5); rd(0, v); chk("R2", v, 8'h25);

        // R3/R4 exhaustive seconds sweep in both encodings
        for (int bm = 0; bm < 2; bm++) begin
            bin_mode = bm[0]; hr24 = 1'b1;
            tag = bm ? "R4 sweep" : "R3 sweep";
            set_time(5, 7, 0, 2, 3, 6, 40);
            for (int i = 1; i <= 61; i++) begin
                upd();
                rd(0, v); chk(tag, v, benc(i % 60));
                rd(1, v); chk(tag, v, benc(i >= 60 ? 8 : 7));
            end
        end

        // R3/R4/R5 every hour boundary in all four encodings
        for (int cfg = 0; cfg < 4; cfg++) begin
            bin_mode = cfg[0]; hr24 = cfg[1];
            tag = hr24 ? (bin_mode ? "R4 hour" : "R3 hour") : "R5 hour";
            for (int h = 0; h < 24; h++) begin
                set_time(h, 59, 58, 3, 10, 5, 30);
                upd();
                rd(0, v); chk(tag, v, benc(59));
                upd();
                if (h == 23) chk_time(tag, 0, 0, 0, 4, 11, 5, 30);
                else         chk_time(tag, h + 1, 0, 0, 3, 10, 5, 30);
            end
        end

        // R6 month ends, leap and non-leap, year wrap
        bin_mode = 1'b0; hr24 = 1'b1;
        for (int yi = 0; yi < 3; yi++) begin
            int y;
            y = (yi == 0) ? 23 : ((yi == 1) ? 24 : 99);
            for (int mo = 1; mo <= 12; mo++) begin
                int dm;
                dm = mlen(mo, y);
                set_time(23, 59, 59, 5, dm - 1, mo, y);
                upd();
                chk_time("R6 no wrap", 0, 0, 0, 6, dm, mo, y);
                set_time(23, 59, 59, 7, dm, mo, y);
                upd();
                chk_time("R6 wrap", 0, 0, 0, 1, 1, (mo == 12) ? 1 : mo + 1,
                         (mo == 12) ? (y + 1) % 100 : y);
            end
        end

        // R7 alarm compare, exact and don't-care
        bin_mode = 1'b0; hr24 = 1'b1;
        wr(7, 8'h30); wr(8, 8'h15); wr(9, 8'h10);
        set_time(10, 15, 29, 2, 4, 4, 24);
        upd(); chk("R7 exact", a_seen, 1);
        upd(); chk("R7 miss", a_seen, 0);
        rd(7, v); chk("R7 alm kept", v, 8'h30);
        rd(9, v); chk("R7 alm kept", v, 8'h10);
        wr(7, 8'h05); wr(8, 8'hFF); wr(9, 8'hC0);
        set_time(7, 33, 4, 2, 4, 4, 24);
        upd(); chk("R7 dc", a_seen, 1);
        upd(); chk("R7 dc miss", a_seen, 0);
        set_time(19, 2, 4, 2, 4, 4, 24);
        upd(); chk("R7 dc hr", a_seen, 1);
        wr(7, 8'hC3);
        upd(); chk("R7 all dc", a_seen, 1);
        upd(); chk("R7 all dc", a_seen, 1);

        // R11 pulse timing
        chk("R11 first", u_first, 0);
        chk("R11 second", u_seen, 1);
        @(negedge clk); chk("R11 end", uend_pulse, 0);
        chk("R11 alarm end", alarm_pulse, 0);
        wr(7, 8'h00); wr(8, 8'h00); wr(9, 8'h00);

        // R8 spring forward
        dst_en = 1'b1;
        set_time(1, 59, 59, 1, 7, 4, 24);
        upd(); chk_time("R8 jump", 3, 0, 0, 1, 7, 4, 24);
        set_time(1, 59, 59, 1, 8, 4, 24);
        upd(); chk_time("R8 late", 2, 0, 0, 1, 8, 4, 24);
        dst_en = 1'b0;
        set_time(1, 59, 59, 1, 7, 4, 24);
        upd(); chk_time("R8 off", 2, 0, 0, 1, 7, 4, 24);

        // R9 fall back once per day
        dst_en = 1'b1;
        set_time(1, 59, 59, 1, 27, 10, 24);
        upd(); chk_time("R9 back", 1, 0, 0, 1, 27, 10, 24);
        wr(1, benc(59)); wr(0, benc(59));
        upd(); chk_time("R9 once", 2, 0, 0, 1, 27, 10, 24);
        set_time(23, 59, 59, 1, 27, 10, 24);
        upd();
        set_time(1, 59, 59, 1, 28, 10, 24);
        upd(); chk_time("R9 rearm", 1, 0, 0, 1, 28, 10, 24);
        dst_en = 1'b0;

        // R10 hold user copy
        bin_mode = 1'b1;
        set_time(0, 0, 10, 2, 3, 3, 21);
        @(negedge clk); hold_user = 1'b1;
        upd(); upd(); upd();
        chk_time("R10 frozen", 0, 0, 10, 2, 3, 3, 21);
        @(negedge clk); hold_user = 1'b0;
        upd();
        chk_time("R10 resume", 0, 0, 14, 2, 3, 3, 21);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule